// File: doc/BRIEF.md
# Steered Interrupt Controller

This block collects 32 interrupt sources and turns them into two interrupt lines for a processor. Each source can be set to level or edge sensing and to either polarity. A per-source class bit routes it to the normal line or to the critical (machine-check) line. Inputs are asynchronous, so they pass through a two-flop synchroniser. A triggered source sets a sticky status bit. Software clears that bit by writing a one to it.

A single-cycle register port gives access to all per-source settings. The port takes a write strobe, a 3-bit register select and 32 data bits, and reads back combinationally. In every per-source register, source n sits at bit 31-n, so source 0 is the most significant bit. Sources 17, 18 and 19 are reserved and never raise anything. Alongside the two lines, the block gives the number of the winning pending source and a valid flag. One configuration bit chooses whether the lowest or the highest source number wins.

Top module: `sic_top`

## Requirements
- R1: After reset the registers read as follows: enable 0, status 0, polarity 0, trigger 0, class 0xFFFFFFFF and configuration 0. Both interrupt lines, the source number and the valid flag are low.
- R2: Sources 17, 18 and 19 are reserved. Their status, enable and masked-status bits (register bits 14, 13 and 12) always read 0. Writes to them are ignored, and a reserved input never raises an interrupt line.
- R3: Register select codes are: 0 enable, 1 status, 2 masked status, 3 trigger, 4 polarity, 5 class, 6 configuration. In every per-source register, source n is at bit 31-n.
- R4: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R5: A level-sensed source (trigger bit 0) sets its status bit while its input is active. Polarity bit 0 means active-low and 1 means active-high. The status bit appears on the third clock edge after the input change.
- R6: An edge-sensed source (trigger bit 1) sets its status bit on an inactive-to-active transition. With polarity 1 this is a rising edge, and with polarity 0 a falling edge. A single-cycle pulse is enough, and the bit stays set after the input returns.
- R7: Enabled pending sources drive the outputs through their class bit, one clock edge after status changes. Class bit 1 drives irq_norm_o and class bit 0 drives irq_crit_o. Each line is the OR of its class.
- R8: vec_valid_o is high when any enabled source is pending. vec_id_o gives the highest-numbered such source when configuration bit 0 is 0, and the lowest-numbered when it is 1. Both outputs are registered one edge after status or configuration changes.
- R9: Clearing a level-sensed status bit while its input is still active has no lasting effect, because the bit sets again at once.
- R10: Masked status reads as status AND enable, and writes to it are ignored.
- R11: When a new edge and a write-1 clear hit the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt inputs; bit n is source n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the selected register (combinational) |
| irq_norm_o | output | 1 | Normal interrupt line |
| irq_crit_o | output | 1 | Critical (machine-check) interrupt line |
| vec_id_o | output | 5 | Number of the winning pending source |
| vec_valid_o | output | 1 | A pending enabled source exists |

## Verification
A corrupted status bit reaches the status read port in the same cycle. It reaches the interrupt lines and the source number one edge later, so a lost or spurious pending bit shows within a cycle of the fault. Wrong edge-detector or synchroniser state shows as a status bit that is missing or extra three edges after an input change. A bad polarity or trigger setting shows the same way. A wrong priority direction shows only when two enabled sources are pending together, so the bench sets up that case in both configurations.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int NSRC = 32;
  localparam int IDW  = $clog2(NSRC);
  localparam int AW   = 3;

  typedef enum logic [AW-1:0] {
    A_ENA   = 3'd0,
    A_STAT  = 3'd1,
    A_MSTAT = 3'd2,
    A_TRIG  = 3'd3,
    A_POL   = 3'd4,
    A_CLASS = 3'd5,
    A_VCFG  = 3'd6
  } reg_sel_e;

  // register view <-> source-indexed view (source n at register bit NSRC-1-n)
  function automatic logic [NSRC-1:0] flip(input logic [NSRC-1:0] v);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = v[NSRC-1-i];
    return r;
  endfunction

  // source-indexed mask of the reserved range
  function automatic logic [NSRC-1:0] rsv_mask(input int lo, input int hi);
    logic [NSRC-1:0] m;
    for (int i = 0; i < NSRC; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction
endpackage

// File: rtl/sic_front.sv
module sic_front #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [N-1:0] act, act_prev, rise;

  // reset to all ones: inactive under the default active-low polarity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    act      = ~(sync_q ^ pol_i);
    act_prev = ~(prev_q ^ pol_i);
    rise     = act & ~act_prev;
  end

  for (genvar g = 0; g < N; g++) begin : g_sense
    assign hit_o[g] = trig_i[g] ? rise[g] : act[g];
  end
endmodule

// File: rtl/sic_encoder.sv
module sic_encoder #(
  parameter int N   = 32,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]   pend_i,
  input  logic           lo_first_i,
  output logic [IDW-1:0] id_o,
  output logic           any_o
);
  logic [IDW-1:0] id_lo, id_hi;

  always_comb begin
    id_lo = '0;
    for (int i = N-1; i >= 0; i--) if (pend_i[i]) id_lo = IDW'(i);
    id_hi = '0;
    for (int i = 0; i < N; i++) if (pend_i[i]) id_hi = IDW'(i);
    id_o  = lo_first_i ? id_lo : id_hi;
    any_o = |pend_i;
  end
endmodule

// File: rtl/sic_top.sv
module sic_top #(
  parameter int RSV_LO = 17,
  parameter int RSV_HI = 19
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [sic_pkg::NSRC-1:0]  src_i,
  input  logic                      wr_en_i,
  input  logic [sic_pkg::AW-1:0]    addr_i,
  input  logic [sic_pkg::NSRC-1:0]  wr_data_i,
  output logic [sic_pkg::NSRC-1:0]  rd_data_o,
  output logic                      irq_norm_o,
  output logic                      irq_crit_o,
  output logic [sic_pkg::IDW-1:0]   vec_id_o,
  output logic                      vec_valid_o
);
  import sic_pkg::*;

  localparam logic [NSRC-1:0] KEEP = ~rsv_mask(RSV_LO, RSV_HI);

  // per-source state, indexed by source number
  logic [NSRC-1:0] stat_q, en_q, cls_q, pol_q, trig_q;
  logic            vcfg_q;
  logic [NSRC-1:0] stat_d, en_d, cls_d, pol_d, trig_d;
  logic            vcfg_d;
  logic            en_we, cls_we, pol_we, trig_we, vcfg_we;

  logic [NSRC-1:0] wr_vec, clr_vec, hit, mstat;
  logic [IDW-1:0]  enc_id;
  logic            enc_any;
  logic            norm_d, crit_d;

  sic_front #(.N(NSRC)) u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .pol_i  (pol_q),
    .trig_i (trig_q),
    .hit_o  (hit)
  );

  assign mstat = stat_q & en_q;

  sic_encoder #(.N(NSRC), .IDW(IDW)) u_enc (
    .pend_i     (mstat),
    .lo_first_i (vcfg_q),
    .id_o       (enc_id),
    .any_o      (enc_any)
  );

  // next-state
  always_comb begin
    wr_vec  = flip(wr_data_i);
    en_we   = wr_en_i && (addr_i == A_ENA);
    cls_we  = wr_en_i && (addr_i == A_CLASS);
    pol_we  = wr_en_i && (addr_i == A_POL);
    trig_we = wr_en_i && (addr_i == A_TRIG);
    vcfg_we = wr_en_i && (addr_i == A_VCFG);
    clr_vec = (wr_en_i && (addr_i == A_STAT)) ? wr_vec : '0;
    // a fresh hit outranks a clear in the same cycle
    stat_d  = ((stat_q & ~clr_vec) | hit) & KEEP;
    en_d    = wr_vec & KEEP;
    cls_d   = wr_vec;
    pol_d   = wr_vec;
    trig_d  = wr_vec;
    vcfg_d  = wr_data_i[0];
    norm_d  = |(mstat & cls_q);
    crit_d  = |(mstat & ~cls_q);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q      <= '0;
      en_q        <= '0;
      cls_q       <= '1;
      pol_q       <= '0;
      trig_q      <= '0;
      vcfg_q      <= 1'b0;
      irq_norm_o  <= 1'b0;
      irq_crit_o  <= 1'b0;
      vec_id_o    <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (en_we)   en_q   <= en_d;
      if (cls_we)  cls_q  <= cls_d;
      if (pol_we)  pol_q  <= pol_d;
      if (trig_we) trig_q <= trig_d;
      if (vcfg_we) vcfg_q <= vcfg_d;
      irq_norm_o  <= norm_d;
      irq_crit_o  <= crit_d;
      vec_id_o    <= enc_id;
      vec_valid_o <= enc_any;
    end
  end

  // read mux
  always_comb begin
    unique case (addr_i)
      A_ENA:   rd_data_o = flip(en_q);
      A_STAT:  rd_data_o = flip(stat_q);
      A_MSTAT: rd_data_o = flip(mstat);
      A_TRIG:  rd_data_o = flip(trig_q);
      A_POL:   rd_data_o = flip(pol_q);
      A_CLASS: rd_data_o = flip(cls_q);
      A_VCFG:  rd_data_o = {{(NSRC-1){1'b0}}, vcfg_q};
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/sic_chk.sv
module sic_chk #(
  parameter int RSV_LO = 17,
  parameter int RSV_HI = 19
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [sic_pkg::AW-1:0]   addr_i,
  input logic [sic_pkg::NSRC-1:0] wr_data_i,
  input logic [sic_pkg::NSRC-1:0] stat_q,
  input logic [sic_pkg::NSRC-1:0] en_q,
  input logic [sic_pkg::NSRC-1:0] cls_q,
  input logic                     irq_norm_o,
  input logic                     irq_crit_o,
  input logic [sic_pkg::IDW-1:0]  vec_id_o,
  input logic                     vec_valid_o
);
  import sic_pkg::*;

  localparam logic [NSRC-1:0] RSVM = rsv_mask(RSV_LO, RSV_HI);

  logic [NSRC-1:0] clr_c;
  assign clr_c = (wr_en_i && (addr_i == A_STAT)) ? flip(wr_data_i) : '0;

  AST_RSV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q | en_q) & RSVM) == '0); // R2

  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !((int'(vec_id_o) >= RSV_LO) && (int'(vec_id_o) <= RSV_HI))); // R2

  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q) & ~$past(clr_c) & ~stat_q) == '0)); // R4

  AST_CRIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_crit_o) |-> ($past(stat_q & en_q & ~cls_q) != '0)); // R7

  AST_NORM_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_norm_o) |-> ($past(stat_q & en_q & cls_q) != '0)); // R7

  AST_VALID_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o == (irq_norm_o || irq_crit_o)); // R8
endmodule

bind sic_top sic_chk #(.RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wr_data_i   (wr_data_i),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .cls_q       (cls_q),
  .irq_norm_o  (irq_norm_o),
  .irq_crit_o  (irq_crit_o),
  .vec_id_o    (vec_id_o),
  .vec_valid_o (vec_valid_o)
);

// File: tb/sic_top_tb_top.sv
module sic_top_tb_top;
  localparam logic [2:0] S_ENA = 3'd0, S_STAT = 3'd1, S_MSTAT = 3'd2,
                         S_TRIG = 3'd3, S_POL = 3'd4, S_CLASS = 3'd5, S_VCFG = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_norm, irq_crit, vec_valid;
  logic [4:0]  vec_id;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sic_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_norm_o(irq_norm),
    .irq_crit_o(irq_crit), .vec_id_o(vec_id), .vec_valid_o(vec_valid)
  );

  function automatic logic [31:0] b(input int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(S_ENA, v);   chk("R1 enable", v, 32'h0);
    rd(S_STAT, v);  chk("R1 status", v, 32'h0);
    rd(S_POL, v);   chk("R1 polarity", v, 32'h0);
    rd(S_TRIG, v);  chk("R1 trigger", v, 32'h0);
    rd(S_CLASS, v); chk("R1 class", v, 32'hFFFF_FFFF);
    rd(S_VCFG, v);  chk("R1 config", v, 32'h0);
    chk("R1 outputs", {irq_norm, irq_crit, vec_valid, vec_id}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(S_ENA, b(3));
    src[3] = 1'b0;
    wait_n(5);
    rd(S_STAT, v);  chk("R5 level low sets bit 28", v, b(3));
    rd(S_MSTAT, v); chk("R10 masked status", v, b(3));
    chk("R7 normal line", {irq_norm, irq_crit}, 32'h2);
    chk("R8 id/valid single", {vec_valid, vec_id}, {26'h0, 1'b1, 5'd3});
    wr(S_MSTAT, 32'h0);
    rd(S_MSTAT, v); chk("R10 masked write ignored", v, b(3));
    wr(S_STAT, b(3));
    wait_n(2);
    rd(S_STAT, v);  chk("R9 re-sets while active", v, b(3));
    src[3] = 1'b1;
    wait_n(4);
    wr(S_STAT, 32'h0);
    rd(S_STAT, v);  chk("R4 write 0 keeps, sticky", v, b(3));
    wr(S_STAT, b(3));
    wait_n(3);
    rd(S_STAT, v);  chk("R4 write 1 clears", v, 32'h0);
    chk("R7 lines drop", {irq_norm, irq_crit, vec_valid}, 32'h0);
    wr(S_ENA, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(S_ENA, 32'hFFFF_FFFF);
    rd(S_ENA, v); chk("R2 enable reserved zero", v, 32'hFFFF_8FFF);
    src[18] = 1'b0;
    wait_n(5);
    rd(S_STAT, v); chk("R2 reserved status zero", v, 32'h0);
    chk("R2 no line from reserved", {irq_norm, irq_crit, vec_valid}, 32'h0);
    src[18] = 1'b1;
    wr(S_ENA, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    src[5] = 1'b0;
    wait_n(3);
    wr(S_TRIG, b(5));
    wr(S_POL, b(5));
    wait_n(3);
    wr(S_STAT, b(5));
    wr(S_ENA, b(5));
    wait_n(2);
    rd(S_STAT, v); chk("R6 quiet when low", v, 32'h0);
    @(negedge clk) src[5] = 1'b1;
    @(negedge clk) src[5] = 1'b0;
    wait_n(5);
    rd(S_STAT, v); chk("R6 pulse latched", v, b(5));
    chk("R7 normal from edge", {irq_norm, irq_crit, vec_id}, {25'h0, 2'b10, 5'd5});
    wr(S_STAT, b(5));
    wait_n(3);
    rd(S_STAT, v); chk("R6 stays clear", v, 32'h0);
    chk("R7 line low", {irq_norm, irq_crit}, 32'h0);
  endtask

  task automatic t_crit_collide();
    logic [31:0] v;
    wr(S_CLASS, ~b(5));
    @(negedge clk) src[5] = 1'b1;
    @(negedge clk) src[5] = 1'b0;
    wait_n(5);
    chk("R7 critical routing", {irq_norm, irq_crit}, 32'h1);
    // status now set; new rising edge lands with a clear in the same cycle
    @(negedge clk) src[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = S_STAT; wdata = b(5);
    @(negedge clk);
    wr_en = 1'b0;
    wait_n(1);
    rd(S_STAT, v); chk("R11 edge beats clear", v, b(5));
    wr(S_ENA, 32'h0);
    wr(S_POL, 32'h0);
    wr(S_TRIG, 32'h0);
    wr(S_CLASS, 32'hFFFF_FFFF);
    wait_n(3);
    wr(S_STAT, 32'hFFFF_FFFF);
    rd(S_STAT, v); chk("R4 cleanup clear", v, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    src[2] = 1'b0; src[30] = 1'b0;
    wr(S_ENA, b(2) | b(30));
    wait_n(5);
    chk("R8 highest number wins", {vec_valid, vec_id}, {26'h0, 1'b1, 5'd30});
    wr(S_VCFG, 32'h1);
    wait_n(1);
    chk("R8 lowest number wins", {vec_valid, vec_id}, {26'h0, 1'b1, 5'd2});
    wr(S_ENA, b(2));
    rd(S_STAT, v);  chk("R3 bit 29 and bit 1", v, 32'h2000_0002);
    rd(S_MSTAT, v); chk("R10 masked subset", v, b(2));
    src[2] = 1'b1; src[30] = 1'b1;
    wr(S_ENA, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_level();
    t_reserved();
    t_edge();
    t_crit_collide();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule